// File: doc/BRIEF.md
# Gapped-Clock Serial Cell Link

This block carries an ATM byte stream over a pair of one-bit serial lines toward the network side. The modem side supplies the clock on both lines. Each clock is a free-running system clock qualified by an enable that the block drives. A cycle with the enable low is a gap: no bit moves. Both enables and the receive data bit come from registers.

In the transmit direction (network to modem), the block samples one bit on every cycle in which its transmit clock enable is high. It assembles the bits MSB first into bytes and hands each finished byte inward as a one-cycle pulse. The block opens gaps on request, either to throttle the far end or to force byte realignment. It counts the length of every gap. A gap longer than a programmable 16-bit threshold marks the next sampled bit as the MSB of a fresh byte, and any partial byte is dropped. A gap no longer than the threshold only pauses the assembly. The network's idle cells are not treated specially and pass through as ordinary bytes.

In the receive direction (modem to network), the block accepts bytes from the internal side with a valid/ready pair and shifts them out MSB first. The receive clock enable is high only while a byte's bits are going out. The clock stops at a byte boundary when nothing is queued, and a byte that has started is never interrupted.

Top module: `gapser_link`

## Requirements
- R1: While reset is high and on the first cycle after it, `txs_clk_en`, `rxs_clk_en` and `tx_out_valid` are 0 and `rx_in_ready` is 1.
- R2: Transmit bits are sampled only on cycles with `txs_clk_en` high. They are packed MSB first (the first sampled bit lands in bit 7). After the eighth sampled bit, `tx_out_data` carries the byte while `tx_out_valid` pulses high for one cycle.
- R3: A transmit gap whose length in cycles is at most `gap_thresh` leaves the partial byte intact, and assembly resumes with the next bit.
- R4: A transmit gap whose length is strictly greater than `gap_thresh` drops any partial byte, and the next sampled bit becomes bit 7 of a new byte. With a threshold of 0, a one-cycle gap is enough.
- R5: `tx_hold` high at a clock edge forces `txs_clk_en` low in the following cycle. Holding it across L edges gives a gap of exactly L cycles.
- R6: A one-cycle `tx_align_req` with `tx_hold` low produces a gap of exactly `gap_thresh`+1 cycles, so the next bit starts a byte. If a hold overlaps the request, the gap lasts until both have ended.
- R7: The gap length counter saturates at 65535. With `gap_thresh` = 65535, even a much longer gap only pauses assembly.
- R8: Transmit bytes are passed on regardless of their content. The idle-cell header octets 0x00, 0x00, 0x00, 0x01 come out unchanged and in order.
- R9: Each byte accepted on `rx_in_data` appears on `rxs_data` MSB first over exactly 8 cycles with `rxs_clk_en` high. `rxs_data` is meaningful only on those cycles.
- R10: Once a receive byte has started, `rxs_clk_en` stays high until its eighth bit. When no byte is offered at a byte boundary, `rxs_clk_en` goes low and stays low until one is.
- R11: `rx_in_ready` is high only at a byte boundary. A byte offered at each boundary keeps `rxs_clk_en` continuously high across consecutive bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst | input | 1 | Synchronous active-high reset |
| gap_thresh | input | 16 | Gap length threshold in cycles that separates pause from realignment |
| tx_hold | input | 1 | Flow-control request to gap the transmit clock |
| tx_align_req | input | 1 | One-cycle request for a realigning gap of threshold+1 cycles |
| txs_clk_en | output | 1 | Transmit serial clock enable driven to the network |
| txs_data | input | 1 | Transmit serial data bit from the network |
| tx_out_data | output | 8 | Assembled transmit byte |
| tx_out_valid | output | 1 | One-cycle strobe for `tx_out_data` |
| rx_in_data | input | 8 | Receive byte to serialise |
| rx_in_valid | input | 1 | `rx_in_data` is offered |
| rx_in_ready | output | 1 | Byte boundary reached; an offered byte is taken at this edge |
| rxs_clk_en | output | 1 | Receive serial clock enable driven to the network |
| rxs_data | output | 1 | Receive serial data bit to the network |

## Verification
Two transmit functions can coincide: a flow-control hold and an alignment request. The bench raises both on the same cycle, with the hold shorter than the alignment window. It then measures the resulting gap from `txs_clk_en` and checks that it equals the longer of the two, and that the bits before the gap are dropped while the following byte comes out whole. On the receive side, the end of one byte and the acceptance of the next share a single edge. Back-to-back bytes are therefore judged by counting falling edges of `rxs_clk_en` and any low cycles inside a byte.

// File: rtl/gapser_pkg.sv
package gapser_pkg;
  localparam int BYTE_BITS = 8;
  localparam int CNT_W     = $clog2(BYTE_BITS);
  typedef logic [BYTE_BITS-1:0] byte_t;
endpackage

// File: rtl/tx_gap_ctrl.sv
module tx_gap_ctrl #(
  parameter int GAP_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  logic             align_req,
  input  logic [GAP_W-1:0] thresh,
  output logic             clk_en,
  output logic [GAP_W-1:0] gap_cnt
);
  localparam logic [GAP_W-1:0] GAP_MAX = '1;
  localparam logic [GAP_W:0]   WIN_ONE = (GAP_W+1)'(1);

  // remaining cycles of an alignment gap, wide enough for thresh+1
  logic [GAP_W:0] win_left;

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_en   <= 1'b0;
      gap_cnt  <= '0;
      win_left <= '0;
    end else begin
      if (align_req)
        win_left <= {1'b0, thresh} + WIN_ONE;
      else if (win_left != '0)
        win_left <= win_left - WIN_ONE;
      clk_en <= !(hold || align_req || (win_left > WIN_ONE));
      if (clk_en)
        gap_cnt <= '0;
      else if (gap_cnt != GAP_MAX)
        gap_cnt <= gap_cnt + 1'b1;
    end
  end

  assert_hold_gaps_R5: assert property (@(posedge clk) disable iff (rst)
    hold |=> !clk_en);
  assert_align_gaps_R6: assert property (@(posedge clk) disable iff (rst)
    align_req |=> !clk_en);
  assert_gap_saturates_R7: assert property (@(posedge clk) disable iff (rst)
    (!clk_en && gap_cnt == GAP_MAX) |=> (gap_cnt == GAP_MAX));
  assert_gap_restarts_R3: assert property (@(posedge clk) disable iff (rst)
    clk_en |=> (gap_cnt == '0));
endmodule

// File: rtl/tx_deser.sv
module tx_deser
  import gapser_pkg::*;
#(
  parameter int GAP_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             sdata,
  input  logic [GAP_W-1:0] gap_cnt,
  input  logic [GAP_W-1:0] thresh,
  output byte_t            out_data,
  output logic             out_valid
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_BITS-1);

  byte_t            shreg;
  logic [CNT_W-1:0] nbits;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg     <= '0;
      nbits     <= '0;
      out_data  <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      if (en) begin
        if (gap_cnt > thresh) begin
          // long gap: this bit opens a new byte, partial bits are dropped
          shreg <= {{(BYTE_BITS-1){1'b0}}, sdata};
          nbits <= CNT_W'(1);
        end else begin
          shreg <= {shreg[BYTE_BITS-2:0], sdata};
          if (nbits == LAST_BIT) begin
            out_data  <= {shreg[BYTE_BITS-2:0], sdata};
            out_valid <= 1'b1;
            nbits     <= '0;
          end else begin
            nbits <= nbits + 1'b1;
          end
        end
      end
    end
  end

  assert_strobe_after_sample_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(en));
  assert_strobe_single_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);
endmodule

// File: rtl/rx_ser.sv
module rx_ser
  import gapser_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  in_valid,
  input  byte_t in_data,
  output logic  in_ready,
  output logic  clk_en,
  output logic  sdata
);
  localparam logic [CNT_W-1:0] FULL_REM = CNT_W'(BYTE_BITS-1);

  byte_t            shreg;
  logic [CNT_W-1:0] remain;

  assign in_ready = (remain == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg  <= '0;
      remain <= '0;
      clk_en <= 1'b0;
      sdata  <= 1'b0;
    end else if (remain != '0) begin
      sdata  <= shreg[BYTE_BITS-1];
      shreg  <= {shreg[BYTE_BITS-2:0], 1'b0};
      remain <= remain - 1'b1;
      clk_en <= 1'b1;
    end else if (in_valid) begin
      sdata  <= in_data[BYTE_BITS-1];
      shreg  <= {in_data[BYTE_BITS-2:0], 1'b0};
      remain <= FULL_REM;
      clk_en <= 1'b1;
    end else begin
      clk_en <= 1'b0;
    end
  end

  assert_byte_unbroken_R10: assert property (@(posedge clk) disable iff (rst)
    (remain != '0) |=> clk_en);
  assert_idle_stops_R10: assert property (@(posedge clk) disable iff (rst)
    (remain == '0 && !in_valid) |=> !clk_en);
  assert_msb_first_R9: assert property (@(posedge clk) disable iff (rst)
    (in_ready && in_valid) |=> (clk_en && sdata == $past(in_data[BYTE_BITS-1])));
endmodule

// File: rtl/gapser_link.sv
module gapser_link
  import gapser_pkg::*;
#(
  parameter int GAP_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [GAP_W-1:0] gap_thresh,
  input  logic             tx_hold,
  input  logic             tx_align_req,
  output logic             txs_clk_en,
  input  logic             txs_data,
  output logic [7:0]       tx_out_data,
  output logic             tx_out_valid,
  input  logic [7:0]       rx_in_data,
  input  logic             rx_in_valid,
  output logic             rx_in_ready,
  output logic             rxs_clk_en,
  output logic             rxs_data
);
  logic [GAP_W-1:0] gap_cnt;

  tx_gap_ctrl #(.GAP_W(GAP_W)) u_gap (
    .clk      (clk),
    .rst      (rst),
    .hold     (tx_hold),
    .align_req(tx_align_req),
    .thresh   (gap_thresh),
    .clk_en   (txs_clk_en),
    .gap_cnt  (gap_cnt)
  );

  tx_deser #(.GAP_W(GAP_W)) u_deser (
    .clk      (clk),
    .rst      (rst),
    .en       (txs_clk_en),
    .sdata    (txs_data),
    .gap_cnt  (gap_cnt),
    .thresh   (gap_thresh),
    .out_data (tx_out_data),
    .out_valid(tx_out_valid)
  );

  rx_ser u_ser (
    .clk     (clk),
    .rst     (rst),
    .in_valid(rx_in_valid),
    .in_data (rx_in_data),
    .in_ready(rx_in_ready),
    .clk_en  (rxs_clk_en),
    .sdata   (rxs_data)
  );

  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> (!txs_clk_en && !rxs_clk_en && !tx_out_valid && rx_in_ready));
endmodule

// File: tb/sim_gapser_link.sv
module sim_gapser_link;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] gap_thresh = 16'd4;
  logic        tx_hold = 1'b1;
  logic        tx_align_req = 1'b0;
  logic        txs_data = 1'b0;
  logic        txs_clk_en;
  logic [7:0]  tx_out_data;
  logic        tx_out_valid;
  logic [7:0]  rx_in_data = 8'h00;
  logic        rx_in_valid = 1'b0;
  logic        rx_in_ready;
  logic        rxs_clk_en;
  logic        rxs_data;

  always #10 clk = ~clk;

  gapser_link u0 (
    .clk(clk), .rst(rst), .gap_thresh(gap_thresh),
    .tx_hold(tx_hold), .tx_align_req(tx_align_req),
    .txs_clk_en(txs_clk_en), .txs_data(txs_data),
    .tx_out_data(tx_out_data), .tx_out_valid(tx_out_valid),
    .rx_in_data(rx_in_data), .rx_in_valid(rx_in_valid), .rx_in_ready(rx_in_ready),
    .rxs_clk_en(rxs_clk_en), .rxs_data(rxs_data)
  );

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<190000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // ---------------- network-side transmit model ----------------
  logic fbits [0:127];
  int nbits = 0, evt_at = -1, evt_kind = 0, evt_len = 0;
  int start_id = 0, seen_id = 0, ptr = 0, pause_cnt = 0;
  logic feeding = 1'b0;

  always @(negedge clk) begin
    if (tx_align_req) tx_align_req <= 1'b0;
    if (pause_cnt > 0) begin
      pause_cnt <= pause_cnt - 1;
      if (pause_cnt == 1) tx_hold <= 1'b0;
    end
    if (start_id != seen_id) begin
      seen_id <= start_id;
      feeding <= 1'b1;
      ptr     <= 0;
      tx_hold <= 1'b0;
    end else if (feeding && txs_clk_en && ptr < nbits) begin
      txs_data <= fbits[ptr];
      ptr      <= ptr + 1;
      if (ptr == nbits - 1) begin
        tx_hold <= 1'b1;
        feeding <= 1'b0;
      end else if (ptr == evt_at) begin
        if (evt_kind[0]) begin tx_hold <= 1'b1; pause_cnt <= evt_len; end
        if (evt_kind[1]) tx_align_req <= 1'b1;
      end
    end
  end

  logic [7:0] obuf [0:63];
  int ocnt = 0;
  always @(negedge clk) if (tx_out_valid) begin
    obuf[ocnt] <= tx_out_data;
    ocnt <= ocnt + 1;
  end

  int run = 0, last_gap = 0;
  always @(negedge clk) begin
    if (!txs_clk_en) run <= run + 1;
    else begin
      if (run > 0) last_gap <= run;
      run <= 0;
    end
  end

  // ---------------- network-side receive model ----------------
  logic [7:0] rbuf [0:63];
  logic [7:0] rsh = 8'h00;
  int rcnt = 0, rbc = 0, en_total = 0, midgap = 0, falls = 0;
  logic prev_en = 1'b0;
  always @(negedge clk) begin
    if (rxs_clk_en) begin
      if (rbc % 8 == 7) begin
        rbuf[rcnt] <= {rsh[6:0], rxs_data};
        rcnt <= rcnt + 1;
      end
      rsh <= {rsh[6:0], rxs_data};
      rbc <= rbc + 1;
      en_total <= en_total + 1;
    end else if (rbc % 8 != 0) begin
      midgap <= midgap + 1;
    end
    if (prev_en && !rxs_clk_en) falls <= falls + 1;
    prev_en <= rxs_clk_en;
  end

  // ---------------- helpers ----------------
  task automatic clear_bits();
    nbits = 0;
  endtask

  task automatic add_bits(input logic [7:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      fbits[nbits] = v[i];
      nbits++;
    end
  endtask

  task automatic run_tx(input int thr, input int at, input int kind, input int len, output int base);
    @(posedge clk);
    gap_thresh = thr[15:0];
    evt_at = at; evt_kind = kind; evt_len = len;
    base = ocnt;
    start_id++;
    @(negedge clk);
    @(posedge clk);
    wait (!feeding);
    repeat (14) @(negedge clk);
  endtask

  task automatic rx_push(input logic [7:0] b);
    @(negedge clk);
    rx_in_valid = 1'b1;
    rx_in_data  = b;
    while (!rx_in_ready) @(negedge clk);
    @(negedge clk);
    rx_in_valid = 1'b0;
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!txs_clk_en && !rxs_clk_en && !tx_out_valid, "R1 outputs quiet in reset",
        {txs_clk_en, rxs_clk_en, tx_out_valid}, 0);
    chk(rx_in_ready, "R1 ready in reset", rx_in_ready, 1);
    rst = 1'b0;
    @(negedge clk);
    chk(!txs_clk_en && !rxs_clk_en && !tx_out_valid && rx_in_ready, "R1 first cycle after reset",
        {txs_clk_en, rxs_clk_en, tx_out_valid, rx_in_ready}, 1);
  endtask

  task automatic t_tx_basic();
    int base;
    clear_bits(); add_bits(8'hA5, 8); add_bits(8'h3C, 8);
    run_tx(4, -1, 0, 0, base);
    chk(ocnt - base == 2, "R2 byte count", ocnt - base, 2);
    chk(obuf[base] == 8'hA5, "R2 MSB-first byte 0", obuf[base], 8'hA5);
    chk(obuf[base+1] == 8'h3C, "R2 MSB-first byte 1", obuf[base+1], 8'h3C);
  endtask

  task automatic t_tx_pause();
    int base;
    clear_bits(); add_bits(8'hC3, 8);
    run_tx(5, 3, 1, 5, base);
    chk(last_gap == 5, "R5 hold gap length", last_gap, 5);
    chk(ocnt - base == 1 && obuf[base] == 8'hC3, "R3 gap equal to threshold pauses only", obuf[base], 8'hC3);
  endtask

  task automatic t_tx_realign();
    int base;
    clear_bits(); add_bits(8'h0A, 4); add_bits(8'h5E, 8);
    run_tx(5, 3, 1, 6, base);
    chk(last_gap == 6, "R5 hold gap length 6", last_gap, 6);
    chk(ocnt - base == 1, "R4 partial dropped", ocnt - base, 1);
    chk(obuf[base] == 8'h5E, "R4 realigned byte", obuf[base], 8'h5E);
  endtask

  task automatic t_tx_zero();
    int base;
    clear_bits(); add_bits(8'h06, 3); add_bits(8'h99, 8);
    run_tx(0, 2, 1, 1, base);
    chk(ocnt - base == 1 && obuf[base] == 8'h99, "R4 threshold 0 one-cycle gap", obuf[base], 8'h99);
  endtask

  task automatic t_tx_align();
    int base;
    clear_bits(); add_bits(8'h07, 3); add_bits(8'h81, 8);
    run_tx(3, 2, 2, 0, base);
    chk(last_gap == 4, "R6 align gap thresh+1", last_gap, 4);
    chk(ocnt - base == 1 && obuf[base] == 8'h81, "R6 align starts byte", obuf[base], 8'h81);
  endtask

  task automatic t_tx_both();
    int base;
    clear_bits(); add_bits(8'h01, 2); add_bits(8'h7E, 8);
    run_tx(3, 1, 3, 2, base);
    chk(last_gap == 4, "R6 hold and align merged gap", last_gap, 4);
    chk(ocnt - base == 1 && obuf[base] == 8'h7E, "R6 merged gap realigns", obuf[base], 8'h7E);
  endtask

  task automatic t_tx_idle_cell();
    int base;
    clear_bits();
    add_bits(8'h00, 8); add_bits(8'h00, 8); add_bits(8'h00, 8); add_bits(8'h01, 8);
    run_tx(4, -1, 0, 0, base);
    chk(ocnt - base == 4, "R8 idle header count", ocnt - base, 4);
    chk(obuf[base] == 8'h00 && obuf[base+1] == 8'h00 && obuf[base+2] == 8'h00,
        "R8 idle header zeros", {obuf[base], obuf[base+1], obuf[base+2]}, 0);
    chk(obuf[base+3] == 8'h01, "R8 idle header last", obuf[base+3], 8'h01);
  endtask

  task automatic t_tx_saturate();
    int base;
    clear_bits(); add_bits(8'hC3, 8);
    run_tx(65535, 3, 1, 70000, base);
    chk(last_gap == 70000, "R7 long gap length", last_gap, 70000);
    chk(ocnt - base == 1 && obuf[base] == 8'hC3, "R7 saturated gap pauses only", obuf[base], 8'hC3);
  endtask

  task automatic t_rx_stream();
    int f0, e0, r0;
    f0 = falls; e0 = en_total; r0 = rcnt;
    @(negedge clk);
    rx_in_valid = 1'b1; rx_in_data = 8'hF0;
    while (!rx_in_ready) @(negedge clk);
    @(negedge clk);
    chk(!rx_in_ready, "R11 ready low mid-byte", rx_in_ready, 0);
    chk(rxs_clk_en, "R9 clock on after load", rxs_clk_en, 1);
    rx_in_data = 8'h1B;
    while (!rx_in_ready) @(negedge clk);
    @(negedge clk);
    rx_in_data = 8'h80;
    while (!rx_in_ready) @(negedge clk);
    @(negedge clk);
    rx_in_valid = 1'b0;
    repeat (12) @(negedge clk);
    chk(rcnt - r0 == 3, "R9 byte count", rcnt - r0, 3);
    chk(rbuf[r0] == 8'hF0 && rbuf[r0+1] == 8'h1B && rbuf[r0+2] == 8'h80, "R9 MSB-first bytes",
        {rbuf[r0], rbuf[r0+1], rbuf[r0+2]}, 24'hF01B80);
    chk(en_total - e0 == 24, "R9 eight clocks per byte", en_total - e0, 24);
    chk(falls - f0 == 1, "R11 continuous clock across bytes", falls - f0, 1);
    chk(midgap == 0, "R10 no gap inside a byte", midgap, 0);
  endtask

  task automatic t_rx_idle();
    int e0, f0, r0;
    e0 = en_total;
    repeat (20) @(negedge clk);
    chk(en_total == e0 && !rxs_clk_en, "R10 clock off while idle", en_total - e0, 0);
    f0 = falls; r0 = rcnt;
    rx_push(8'h5A);
    repeat (15) @(negedge clk);
    rx_push(8'hA5);
    repeat (12) @(negedge clk);
    chk(rcnt - r0 == 2 && rbuf[r0] == 8'h5A && rbuf[r0+1] == 8'hA5, "R10 spaced bytes",
        {rbuf[r0], rbuf[r0+1]}, 16'h5AA5);
    chk(falls - f0 == 2, "R10 clock stops between spaced bytes", falls - f0, 2);
    chk(midgap == 0, "R10 spaced bytes unbroken", midgap, 0);
  endtask

  initial begin
    t_reset();
    t_tx_basic();
    t_tx_pause();
    t_tx_realign();
    t_tx_zero();
    t_tx_align();
    t_tx_both();
    t_tx_idle_cell();
    t_rx_stream();
    t_rx_idle();
    t_tx_saturate();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule